// File: doc/BRIEF.md
# Video Timing Reference Detector

This block sits in front of a serial video encoder. It takes one parallel video word per strobe and accepts either full 10-bit words or 8-bit words. An 8-bit word is widened to 10 bits before anything else happens. The block scans the widened stream for timing reference sequences. A sequence is a near-all-ones word, then two near-all-zero words, then a status word that carries the field, vertical and horizontal bits.

The block confirms a sequence only when the status word arrives. To allow this, it holds words in a three-word delay line. The three preamble words can then be rewritten to exact extreme codes on their way out. Every output word carries flags:
- whether it belongs to a timing reference;
- whether it is the status word;
- whether that status word starts active video (SAV) or ends it (EAV);
- the decoded F/V/H bits;
- whether it is an ordinary word inside active video.

The detect function runs only while an active-low enable input is low.

The input match machine has four states:
- `M_HUNT`: waiting for a ones word.
- `M_SAW_ONES`: a high word was seen.
- `M_SAW_ZERO1`: one low word followed it.
- `M_SAW_ZERO2`: two low words followed it, and the next word is the status word.

Its transitions, each on an accepted word while detection is enabled, are:
- HUNT→SAW_ONES on a high word.
- SAW_ONES→SAW_ZERO1 and SAW_ZERO1→SAW_ZERO2 on a low word.
- SAW_ONES/SAW_ZERO1→SAW_ONES on a high word.
- Any state →HUNT on a mid-range word.
- SAW_ZERO2→HUNT on any word, which confirms the sequence.

An accepted word that enters with detection disabled forces HUNT.

The output region machine has two states, `R_BLANK` and `R_ACTIVE`. An outgoing SAV status word moves it BLANK→ACTIVE. An outgoing EAV status word moves it ACTIVE→BLANK.

Top module: `trs_scan_top`

## Requirements
- R1: With `narrow_mode` high, the word is `in_word[7:0]` followed by two zero bits, so 8'hFF becomes 10'h3FC and 8'h01 becomes 10'h004. With `narrow_mode` low, all ten bits of `in_word` are used unchanged.
- R2: A widened word from 3FCh to 3FFh (high), then two words from 000h to 003h (low), then any fourth word form a timing reference. All four words must be accepted with `det_en_n` low. The fourth word is the status word. Matching restarts after the status word, and `trs_flag` is high on all four output words.
- R3: The first word of a confirmed sequence leaves as exactly 3FFh. The second and third words leave as exactly 000h.
- R4: The status word and every word outside a confirmed sequence leave unchanged, including values in the clip ranges.
- R5: On the status word, `xyz_flag` is high and `fvh_bits` = {bit 8, bit 7, bit 6} = {F, V, H}. `eav_flag` is high when bit 6 is 1, and `sav_flag` is high when bit 6 is 0. On other words these three outputs are zero.
- R6: A word accepted while `det_en_n` is high cannot be part of a sequence. It leaves unchanged with all flags low.
- R7: An accepted word appears on `out_word`, with `out_valid` high for one cycle, in the cycle after the strobe of the third later accepted word. Cycles without a strobe do not advance the stream and show `out_valid` and all flags low.
- R8: `active_flag` is high for a word outside any sequence that was accepted with detection enabled. It requires that the last status word to leave was an SAV and that no EAV has left since.
- R9: A synchronous `rst` clears the stream, both machines and all outputs to zero. The first three words accepted after reset produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: `in_word` is accepted this cycle |
| narrow_mode | input | 1 | 1: word is 8 bits on `in_word[7:0]` |
| det_en_n | input | 1 | Detection enable, active low, sampled with each word |
| in_word | input | 10 | Parallel video word |
| out_valid | output | 1 | Output word present this cycle |
| out_word | output | 10 | Clipped video word |
| trs_flag | output | 1 | Word belongs to a timing reference |
| xyz_flag | output | 1 | Word is the status word |
| sav_flag | output | 1 | Status word marks start of active video |
| eav_flag | output | 1 | Status word marks end of active video |
| fvh_bits | output | 3 | {F, V, H} of the status word |
| active_flag | output | 1 | Ordinary word inside active video |

## Verification
A match machine left in the wrong state shows up as a missed or invented sequence. The damage is visible on the output the cycle after the status word's strobe, when the unclipped ones word leaves with `trs_flag` in the wrong state. It is then repeated on the next two preamble words and the status flags. A wrong region state shows only on `active_flag`, starting with the word after the status word that should have changed it. The sweeps cover every 10-bit and 8-bit code, every combination of clip-range preamble codes with all eight F/V/H settings, disabled words at each sequence position, idle gaps and overlapping candidates.

// File: rtl/trs_pkg.sv
package trs_pkg;

    // Range a widened word falls into for matching purposes
    typedef enum logic [1:0] {
        CL_MID  = 2'd0,
        CL_LOW  = 2'd1,
        CL_HIGH = 2'd2
    } word_class_e;

    // Input-side sequence matcher
    typedef enum logic [1:0] {
        M_HUNT      = 2'd0,
        M_SAW_ONES  = 2'd1,
        M_SAW_ZERO1 = 2'd2,
        M_SAW_ZERO2 = 2'd3
    } match_state_e;

    // Output-side video region tracker
    typedef enum logic {
        R_BLANK  = 1'b0,
        R_ACTIVE = 1'b1
    } region_state_e;

    // Role a word plays once its sequence is settled
    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_ONES  = 2'd1,
        K_ZERO  = 2'd2,
        K_XYZ   = 2'd3
    } word_kind_e;

    typedef struct packed {
        logic       full;
        logic       det_on;
        word_kind_e kind;
    } slot_meta_t;

    localparam int PREAMBLE_LEN = 3;
    localparam int F_BIT        = 8;
    localparam int V_BIT        = 7;
    localparam int H_BIT        = 6;

endpackage

// File: rtl/trs_word_widen.sv
module trs_word_widen
    import trs_pkg::*;
#(
    parameter int WIDE_W    = 10,
    parameter int NARROW_W  = 8,
    parameter int CLIP_BITS = 2
) (
    input  logic              narrow_mode,
    input  logic [WIDE_W-1:0] raw_word,
    output logic [WIDE_W-1:0] wide_word,
    output word_class_e       word_class
);

    localparam int PAD_W = WIDE_W - NARROW_W;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                if (narrow_mode) begin
                    wide_word = {raw_word[NARROW_W-1:0], {PAD_W{1'b0}}};
                end else begin
                    wide_word = raw_word;
                end
            end
        end else begin : g_same
            logic unused_mode;
            assign unused_mode = narrow_mode;
            assign wide_word   = raw_word;
        end
    endgenerate

    // Only the bits above the clip span decide the range
    always_comb begin
        if (&wide_word[WIDE_W-1:CLIP_BITS]) begin
            word_class = CL_HIGH;
        end else if (~|wide_word[WIDE_W-1:CLIP_BITS]) begin
            word_class = CL_LOW;
        end else begin
            word_class = CL_MID;
        end
    end

endmodule

// File: rtl/trs_match_fsm.sv
module trs_match_fsm
    import trs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        det_on,
    input  word_class_e word_class,
    output logic        confirm
);

    match_state_e state_q;
    match_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= M_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (step) begin
            if (!det_on) begin
                state_d = M_HUNT;
            end else begin
                unique case (state_q)
                    M_HUNT: begin
                        if (word_class == CL_HIGH) state_d = M_SAW_ONES;
                        else                       state_d = M_HUNT;
                    end
                    M_SAW_ONES: begin
                        if (word_class == CL_LOW)       state_d = M_SAW_ZERO1;
                        else if (word_class == CL_HIGH) state_d = M_SAW_ONES;
                        else                            state_d = M_HUNT;
                    end
                    M_SAW_ZERO1: begin
                        if (word_class == CL_LOW)       state_d = M_SAW_ZERO2;
                        else if (word_class == CL_HIGH) state_d = M_SAW_ONES;
                        else                            state_d = M_HUNT;
                    end
                    M_SAW_ZERO2: begin
                        state_d = M_HUNT;
                    end
                endcase
            end
        end
    end

    // Outputs: the word arriving in SAW_ZERO2 completes a sequence
    always_comb begin
        confirm = step && det_on && (state_q == M_SAW_ZERO2);
    end

endmodule

// File: rtl/trs_align_pipe.sv
module trs_align_pipe
    import trs_pkg::*;
#(
    parameter int WIDE_W = 10,
    parameter int DEPTH  = PREAMBLE_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              confirm,
    input  logic              det_on,
    input  logic [WIDE_W-1:0] in_word,
    output logic [WIDE_W-1:0] dep_word,
    output slot_meta_t        dep_meta
);

    localparam int LAST = DEPTH - 1;

    logic [WIDE_W-1:0] slot_word [DEPTH];
    slot_meta_t        slot_meta [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot_word[k] <= '0;
                slot_meta[k] <= '{full: 1'b0, det_on: 1'b0, kind: K_PLAIN};
            end
        end else if (step) begin
            slot_word[0] <= in_word;
            slot_meta[0] <= '{full: 1'b1, det_on: det_on,
                              kind: (confirm ? K_XYZ : K_PLAIN)};
            for (int k = 1; k < DEPTH; k++) begin
                slot_word[k]        <= slot_word[k-1];
                slot_meta[k].full   <= slot_meta[k-1].full;
                slot_meta[k].det_on <= slot_meta[k-1].det_on;
                slot_meta[k].kind   <= confirm ? K_ZERO : slot_meta[k-1].kind;
            end
        end
    end

    // The oldest word leaves on this step; a confirm marks it as the ones word
    always_comb begin
        dep_word = slot_word[LAST];
        dep_meta = slot_meta[LAST];
        if (confirm) begin
            dep_meta.kind = K_ONES;
        end
    end

endmodule

// File: rtl/trs_out_stage.sv
module trs_out_stage
    import trs_pkg::*;
#(
    parameter int WIDE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [WIDE_W-1:0] dep_word,
    input  slot_meta_t        dep_meta,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_word,
    output logic              trs_flag,
    output logic              xyz_flag,
    output logic              sav_flag,
    output logic              eav_flag,
    output logic [2:0]        fvh_bits,
    output logic              active_flag
);

    region_state_e region_q;
    region_state_e region_d;
    logic          dep_take;
    logic          is_status;

    assign dep_take  = step && dep_meta.full;
    assign is_status = (dep_meta.kind == K_XYZ);

    // Region state register
    always_ff @(posedge clk) begin
        if (rst) begin
            region_q <= R_BLANK;
        end else begin
            region_q <= region_d;
        end
    end

    always_comb begin
        region_d = region_q;
        if (dep_take && is_status) begin
            unique case (region_q)
                R_BLANK:  region_d = dep_word[H_BIT] ? R_BLANK : R_ACTIVE;
                R_ACTIVE: region_d = dep_word[H_BIT] ? R_BLANK : R_ACTIVE;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_word    <= '0;
            trs_flag    <= 1'b0;
            xyz_flag    <= 1'b0;
            sav_flag    <= 1'b0;
            eav_flag    <= 1'b0;
            fvh_bits    <= '0;
            active_flag <= 1'b0;
        end else if (dep_take) begin
            out_valid <= 1'b1;
            unique case (dep_meta.kind)
                K_ONES:  out_word <= '1;
                K_ZERO:  out_word <= '0;
                K_XYZ:   out_word <= dep_word;
                K_PLAIN: out_word <= dep_word;
            endcase
            trs_flag    <= (dep_meta.kind != K_PLAIN);
            xyz_flag    <= is_status;
            sav_flag    <= is_status && !dep_word[H_BIT];
            eav_flag    <= is_status && dep_word[H_BIT];
            fvh_bits    <= is_status ? {dep_word[F_BIT], dep_word[V_BIT], dep_word[H_BIT]}
                                     : 3'b000;
            active_flag <= (dep_meta.kind == K_PLAIN) && dep_meta.det_on
                           && (region_q == R_ACTIVE);
        end else begin
            out_valid   <= 1'b0;
            trs_flag    <= 1'b0;
            xyz_flag    <= 1'b0;
            sav_flag    <= 1'b0;
            eav_flag    <= 1'b0;
            fvh_bits    <= '0;
            active_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/trs_scan_top.sv
module trs_scan_top
    import trs_pkg::*;
#(
    parameter int WIDE_W    = 10,
    parameter int NARROW_W  = 8,
    parameter int CLIP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              narrow_mode,
    input  logic              det_en_n,
    input  logic [WIDE_W-1:0] in_word,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_word,
    output logic              trs_flag,
    output logic              xyz_flag,
    output logic              sav_flag,
    output logic              eav_flag,
    output logic [2:0]        fvh_bits,
    output logic              active_flag
);

    localparam int DEPTH = PREAMBLE_LEN;

    logic [WIDE_W-1:0] wide_word;
    word_class_e       word_class;
    logic              det_on;
    logic              confirm;
    logic [WIDE_W-1:0] dep_word;
    slot_meta_t        dep_meta;

    assign det_on = !det_en_n;

    trs_word_widen #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W),
        .CLIP_BITS(CLIP_BITS)
    ) i_widen (
        .narrow_mode(narrow_mode),
        .raw_word   (in_word),
        .wide_word  (wide_word),
        .word_class (word_class)
    );

    trs_match_fsm i_match (
        .clk       (clk),
        .rst       (rst),
        .step      (in_valid),
        .det_on    (det_on),
        .word_class(word_class),
        .confirm   (confirm)
    );

    trs_align_pipe #(
        .WIDE_W(WIDE_W),
        .DEPTH (DEPTH)
    ) i_pipe (
        .clk     (clk),
        .rst     (rst),
        .step    (in_valid),
        .confirm (confirm),
        .det_on  (det_on),
        .in_word (wide_word),
        .dep_word(dep_word),
        .dep_meta(dep_meta)
    );

    trs_out_stage #(
        .WIDE_W(WIDE_W)
    ) i_out (
        .clk        (clk),
        .rst        (rst),
        .step       (in_valid),
        .dep_word   (dep_word),
        .dep_meta   (dep_meta),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .trs_flag   (trs_flag),
        .xyz_flag   (xyz_flag),
        .sav_flag   (sav_flag),
        .eav_flag   (eav_flag),
        .fvh_bits   (fvh_bits),
        .active_flag(active_flag)
    );

endmodule

// File: rtl/trs_scan_checks.sv
module trs_scan_checks #(
    parameter int WIDE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [WIDE_W-1:0] out_word,
    input logic              trs_flag,
    input logic              xyz_flag,
    input logic              sav_flag,
    input logic              eav_flag,
    input logic [2:0]        fvh_bits,
    input logic              active_flag
);

    AST_STATUS_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        xyz_flag |-> (sav_flag ^ eav_flag)); // R5

    AST_SIDE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (sav_flag || eav_flag || (fvh_bits != 3'b000)) |-> xyz_flag); // R5

    AST_SIDE_MATCHES_H: assert property (@(posedge clk) disable iff (rst)
        eav_flag |-> fvh_bits[0]); // R5

    AST_PREAMBLE_EXTREME: assert property (@(posedge clk) disable iff (rst)
        (trs_flag && !xyz_flag) |-> ((out_word == '0) || (&out_word))); // R3

    AST_STATUS_IN_TRS: assert property (@(posedge clk) disable iff (rst)
        xyz_flag |-> trs_flag); // R2

    AST_ACTIVE_NOT_TRS: assert property (@(posedge clk) disable iff (rst)
        active_flag |-> !trs_flag); // R8

    AST_OUT_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R7

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(trs_flag || xyz_flag || active_flag)); // R7

endmodule

bind trs_scan_top trs_scan_checks #(.WIDE_W(WIDE_W)) i_checks (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .trs_flag   (trs_flag),
    .xyz_flag   (xyz_flag),
    .sav_flag   (sav_flag),
    .eav_flag   (eav_flag),
    .fvh_bits   (fvh_bits),
    .active_flag(active_flag)
);

// File: tb/test_trs_scan_top.sv
module test_trs_scan_top;

    localparam int CLK_PERIOD = 10;
    localparam int HMAX       = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       narrow_mode = 1'b0;
    logic       det_en_n = 1'b1;
    logic [9:0] in_word = '0;
    logic       out_valid;
    logic [9:0] out_word;
    logic       trs_flag, xyz_flag, sav_flag, eav_flag, active_flag;
    logic [2:0] fvh_bits;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  hist_n = 0;
    int  last_p = -100;
    bit  act_reg = 1'b0;
    bit  done = 1'b0;

    logic [9:0] hw   [HMAX];
    bit         hen  [HMAX];
    bit         hnar [HMAX];

    always #(CLK_PERIOD / 2) clk = ~clk;

    trs_scan_top i_trs_scan_top (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .narrow_mode(narrow_mode),
        .det_en_n   (det_en_n),
        .in_word    (in_word),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .trs_flag   (trs_flag),
        .xyz_flag   (xyz_flag),
        .sav_flag   (sav_flag),
        .eav_flag   (eav_flag),
        .fvh_bits   (fvh_bits),
        .active_flag(active_flag)
    );

    // 2 = high clip range, 1 = low clip range, 0 = other
    function automatic int range_of(input logic [9:0] w);
        if (w >= 10'h3FC) return 2;
        if (w <= 10'h003) return 1;
        return 0;
    endfunction

    task automatic chk(input string req, input string what, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (word %0d)", req, what, act_v, exp_v, hist_n);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "out_valid in reset", int'(out_valid), 0);
        chk("R9", "out_word in reset", int'(out_word), 0);
        chk("R9", "flags in reset",
            int'({trs_flag, xyz_flag, sav_flag, eav_flag, fvh_bits, active_flag}), 0);
        rst = 1'b0;
        hist_n  = 0;
        last_p  = -100;
        act_reg = 1'b0;
    endtask

    // Expected output for accepted word i; words i+1..i+3 are already known
    task automatic check_word(input int i);
        bit    pat;
        int    kind;
        int    exp_w;
        string wreq;
        pat = (i > last_p + 3) && (range_of(hw[i]) == 2) && (range_of(hw[i+1]) == 1)
              && (range_of(hw[i+2]) == 1) && hen[i] && hen[i+1] && hen[i+2] && hen[i+3];
        if (pat) last_p = i;
        if (i == last_p) kind = 1;
        else if (i == last_p + 1 || i == last_p + 2) kind = 2;
        else if (i == last_p + 3) kind = 3;
        else kind = 0;

        if (kind == 1) exp_w = 10'h3FF;
        else if (kind == 2) exp_w = 0;
        else exp_w = int'(hw[i]);

        if (kind == 1 || kind == 2) wreq = "R3";
        else if (kind == 3) wreq = "R4";
        else if (hnar[i]) wreq = "R1";
        else if (!hen[i]) wreq = "R6";
        else wreq = "R4";

        chk("R7", "out_valid", int'(out_valid), 1);
        chk(wreq, "out_word", int'(out_word), exp_w);
        chk((kind == 0 && !hen[i]) ? "R6" : "R2", "trs_flag", int'(trs_flag), int'(kind != 0));
        chk("R2", "xyz_flag", int'(xyz_flag), int'(kind == 3));
        chk("R5", "fvh_bits", int'(fvh_bits), (kind == 3) ? int'(hw[i][8:6]) : 0);
        chk("R5", "eav_flag", int'(eav_flag), int'(kind == 3 && hw[i][6]));
        chk("R5", "sav_flag", int'(sav_flag), int'(kind == 3 && !hw[i][6]));
        chk("R8", "active_flag", int'(active_flag), int'(kind == 0 && hen[i] && act_reg));
        if (kind == 3) act_reg = !hw[i][6];
    endtask

    task automatic push(input logic [9:0] raw, input bit nar, input bit en);
        in_word     = raw;
        narrow_mode = nar;
        det_en_n    = !en;
        in_valid    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        hw[hist_n]   = nar ? {raw[7:0], 2'b00} : raw;
        hen[hist_n]  = en;
        hnar[hist_n] = nar;
        hist_n++;
        if (hist_n <= 3) chk("R9", "out_valid before fill", int'(out_valid), 0);
        else check_word(hist_n - 4);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7", "out_valid idle", int'(out_valid), 0);
        chk("R7", "flags idle", int'({trs_flag, xyz_flag, active_flag}), 0);
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) push(10'h200, 1'b0, 1'b1);
    endtask

    task automatic seq4(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c,
                        input logic [9:0] d, input logic [3:0] en_mask);
        push(a, 1'b0, en_mask[0]);
        push(b, 1'b0, en_mask[1]);
        push(c, 1'b0, en_mask[2]);
        push(d, 1'b0, en_mask[3]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Every 10-bit code as ordinary data (R4)
        for (int v = 0; v < 1024; v++) push(10'(v), 1'b0, 1'b1);
        flush();

        // Every clip-range preamble code with every F/V/H setting (R2, R3, R5, R8)
        do_reset();
        for (int h = 0; h < 4; h++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int f = 0; f < 8; f++) begin
                        push(10'(10'h3FC + h), 1'b0, 1'b1);
                        push(10'(a), 1'b0, 1'b1);
                        push(10'(b), 1'b0, 1'b1);
                        push(10'(10'h200 | (f << 6) | (h << 2) | a), 1'b0, 1'b1);
                        push(10'(10'h100 + f), 1'b0, 1'b1);
                        push(10'h2AA, 1'b0, 1'b1);
                    end
        flush();

        // 8-bit words: all codes, then narrow sequences (R1)
        do_reset();
        for (int v = 0; v < 256; v++) push(10'(v), 1'b1, 1'b1);
        for (int f = 0; f < 8; f++) begin
            push(10'h0FF, 1'b1, 1'b1);
            push(10'h000, 1'b1, 1'b1);
            push(10'h000, 1'b1, 1'b1);
            push(10'(8'h80 | (f << 4)), 1'b1, 1'b1);
            push(10'h040, 1'b1, 1'b1);
        end
        push(10'h0FF, 1'b1, 1'b1);
        push(10'h001, 1'b1, 1'b1);
        push(10'h000, 1'b1, 1'b1);
        push(10'h080, 1'b1, 1'b1);
        flush();

        // Detection disabled (R6) inside active video (R8)
        do_reset();
        seq4(10'h3FF, 10'h000, 10'h000, 10'h200, 4'b1111);
        push(10'h111, 1'b0, 1'b1);
        for (int f = 0; f < 8; f++) begin
            seq4(10'h3FF, 10'h000, 10'h003, 10'(10'h200 | (f << 6)), 4'b0000);
            push(10'h155, 1'b0, 1'b1);
            push(10'h156, 1'b0, 1'b0);
        end
        for (int pos = 0; pos < 4; pos++) begin
            seq4(10'h3FF, 10'h000, 10'h000, 10'h240, 4'(4'b1111 & ~(1 << pos)));
            push(10'h0AB, 1'b0, 1'b1);
        end
        seq4(10'h3FF, 10'h000, 10'h000, 10'h240, 4'b1111);
        push(10'h0AC, 1'b0, 1'b1);
        flush();

        // Idle gaps, restarts and overlapping candidates (R2, R7)
        do_reset();
        push(10'h3FF, 1'b0, 1'b1); idle();
        push(10'h001, 1'b0, 1'b1); idle(); idle();
        push(10'h3FE, 1'b0, 1'b1);
        push(10'h000, 1'b0, 1'b1); idle();
        push(10'h002, 1'b0, 1'b1);
        push(10'h200, 1'b0, 1'b1); idle();
        push(10'h123, 1'b0, 1'b1);
        push(10'h3FD, 1'b0, 1'b1);
        push(10'h3FC, 1'b0, 1'b1);
        push(10'h003, 1'b0, 1'b1);
        push(10'h000, 1'b0, 1'b1);
        push(10'h2C0, 1'b0, 1'b1);
        push(10'h124, 1'b0, 1'b1);
        seq4(10'h3FF, 10'h000, 10'h004, 10'h200, 4'b1111);
        seq4(10'h3FC, 10'h000, 10'h000, 10'h3FF, 4'b1111);
        seq4(10'h000, 10'h000, 10'h200, 10'h125, 4'b1111);
        seq4(10'h3FF, 10'h000, 10'h000, 10'h380, 4'b1111);
        idle();
        push(10'h126, 1'b0, 1'b1);
        flush();
        idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule